// File: doc/BRIEF.md
# Audio Lane FIFO Flag and Request Logic

This block produces the status flags, latched error bits and interrupt or DMA requests for a serial audio port that carries four transmit lanes and four receive lanes. Each lane's FIFO reports its current fill level. The FIFO storage is outside this block. The block compares every transmit level with one shared transmit threshold to decide whether a lane needs data. It compares every receive level with one shared receive threshold to decide whether a lane has data ready. The block also watches the pop strobes of the transmit FIFOs and the push strobes of the receive FIFOs, and latches underflow and overflow errors for each lane.

The flags and errors are combined into one interrupt line and two DMA request lines. Each direction can be switched from interrupt service to DMA service. In DMA mode, that direction's threshold flags raise a DMA request and no longer take part in the interrupt. A control write strobe carries five one-cycle pulse commands to the neighbouring logic: a FIFO clear for each direction, and soft resets for the transmit path, the receive path and the clock generator.

Top module: `audio_fifo_flags`

## Requirements
- R1: The fill levels of all lanes arrive packed into one bus, lane i in bits [8i+7:8i], so lane 0 sits in the low byte.
- R2: `tx_need[i]` is high in the same cycle whenever the transmit level of lane i is at or below `tx_thresh`. It is not latched and does not depend on the lane enables.
- R3: `rx_avail[i]` is high in the same cycle whenever the receive level of lane i is at or above `rx_thresh`. It is not latched.
- R4: A pop strobe on an enabled transmit lane whose level is 0 sets that lane's underflow bit at the next clock edge. The bit then stays set until it is cleared. A pop on a disabled lane sets nothing.
- R5: A push strobe on an enabled receive lane whose level is at or above `RX_FULL_LVL` (default 16) sets that lane's overflow bit at the next clock edge. The bit then stays set until it is cleared.
- R6: A status write (`sta_wr` high) with any bit of `sta_uf_clr` set clears all four underflow bits at the next edge. The same holds for `sta_of_clr` and the overflow bits. A write whose clear field is all zero leaves that field unchanged, and each clear field touches only its own error field.
- R7: If an error event and a clearing write arrive in the same cycle, the error event wins and its bit stays set.
- R8: `tx_uflow[i]` shows the latched underflow bit ANDed with `tx_lane_en[i]`. Disabling a lane hides its bit without erasing it, and enabling the lane again shows the bit again.
- R9: `irq` is high when any of these three terms is true: `ien_tx_need` set, TX not in DMA mode, and some enabled TX lane needs data; `ien_rx_avail` set, RX not in DMA mode, and some enabled RX lane has data; `ien_err` set and any reported underflow or overflow bit set.
- R10: `tx_dma_req` (or `rx_dma_req`) is high when its direction is in DMA mode and some enabled lane of that direction raises its threshold flag. This holds whatever the interrupt enables are.
- R11: `ctl_wr` with bit k of `ctl_bits` set drives `ctl_pulse[k]` high for exactly the following cycle. The bits are: 0 TX FIFO clear, 1 RX FIFO clear, 2 TX soft reset, 3 RX soft reset, 4 clock-generator soft reset.
- R12: After reset, all error bits and all control pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_level | input | 32 | Packed transmit FIFO fill levels, lane 0 in low byte |
| rx_level | input | 32 | Packed receive FIFO fill levels, lane 0 in low byte |
| tx_pop | input | 4 | Per-lane transmit FIFO pop strobe |
| rx_push | input | 4 | Per-lane receive FIFO push strobe |
| tx_lane_en | input | 4 | Transmit lane enables |
| rx_lane_en | input | 4 | Receive lane enables |
| tx_thresh | input | 8 | Transmit data-needed threshold |
| rx_thresh | input | 8 | Receive data-ready threshold |
| ien_tx_need | input | 1 | Interrupt enable for transmit data-needed |
| ien_rx_avail | input | 1 | Interrupt enable for receive data-ready |
| ien_err | input | 1 | Interrupt enable for underflow and overflow |
| tx_dma_mode | input | 1 | Transmit direction served by DMA |
| rx_dma_mode | input | 1 | Receive direction served by DMA |
| sta_wr | input | 1 | Status write strobe |
| sta_uf_clr | input | 4 | Write-one-to-clear bits for the underflow field |
| sta_of_clr | input | 4 | Write-one-to-clear bits for the overflow field |
| ctl_wr | input | 1 | Control write strobe |
| ctl_bits | input | 5 | Pulse command bits |
| tx_need | output | 4 | Per-lane transmit data-needed flags |
| rx_avail | output | 4 | Per-lane receive data-ready flags |
| tx_uflow | output | 4 | Reported underflow bits (enable masked) |
| rx_oflow | output | 4 | Latched overflow bits |
| irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| ctl_pulse | output | 5 | One-cycle control pulses |

## Verification
The hardest case to reach is a clearing write that lands in the same cycle as a new error event. The bench first latches overflow on two lanes. Then, on one negative edge, it drives a status write that clears the overflow field together with a push into an already full lane 0. After the next edge it expects only lane 0's bit to remain. The enable mask is tested by disabling a lane that holds a latched underflow, checking that the bit disappears from the output, and enabling the lane again to check that the bit comes back. This shows at the ports that masking did not erase the stored state.

// File: rtl/afs_pkg.sv
package afs_pkg;

  // Positions of the pulse commands in ctl_bits / ctl_pulse
  localparam int CTL_TX_FIFO_CLR = 0;
  localparam int CTL_RX_FIFO_CLR = 1;
  localparam int CTL_TX_SRST     = 2;
  localparam int CTL_RX_SRST     = 3;
  localparam int CTL_CLK_SRST    = 4;
  localparam int CTL_NUM         = 5;

  typedef struct packed {
    logic irq;
    logic tx_dma;
    logic rx_dma;
  } afs_req_t;

endpackage

// File: rtl/afs_thresh_cmp.sv
module afs_thresh_cmp #(
  parameter int LANES  = 4,
  parameter int LVL_W  = 8,
  parameter bit AT_LOW = 1'b1   // 1: flag when level <= thresh, 0: level >= thresh
) (
  input  logic [LANES*LVL_W-1:0] level,
  input  logic [LVL_W-1:0]       thresh,
  output logic [LANES-1:0]       flag
);

  function automatic logic cmp_lvl(input logic [LVL_W-1:0] lvl,
                                   input logic [LVL_W-1:0] th,
                                   input logic low_side);
    if (low_side) return (lvl <= th);
    return (lvl >= th);
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LVL_W-1:0] lane_lvl;
    assign lane_lvl = level[i*LVL_W +: LVL_W];
    assign flag[i]  = cmp_lvl(lane_lvl, thresh, AT_LOW);
  end

endmodule

// File: rtl/afs_err_latch.sv
module afs_err_latch #(
  parameter int LANES     = 4,
  parameter int LVL_W     = 8,
  parameter int FULL_LVL  = 16,
  parameter bit UNDERFLOW = 1'b1  // 1: pop on empty, 0: push on full
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES*LVL_W-1:0] level,
  input  logic [LANES-1:0]       strobe,
  input  logic [LANES-1:0]       lane_en,
  input  logic                   clr,
  output logic [LANES-1:0]       err_q,
  output logic [LANES-1:0]       err_event
);

  localparam logic [LVL_W-1:0] FULL_L = LVL_W'(FULL_LVL);

  function automatic logic hit_fn(input logic [LVL_W-1:0] lvl, input logic uf);
    if (uf) return (lvl == '0);
    return (lvl >= FULL_L);
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_ev
    logic [LVL_W-1:0] lane_lvl;
    assign lane_lvl     = level[i*LVL_W +: LVL_W];
    assign err_event[i] = strobe[i] & lane_en[i] & hit_fn(lane_lvl, UNDERFLOW);
  end

  // new event has priority over the group clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_event | (err_q & {LANES{~clr}});
  end

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    // R4 R5 R7
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_event[i] |=> err_q[i]);
    // R4 R6
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q[i] && !clr) |=> err_q[i]);
    // R6
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !err_event[i]) |=> !err_q[i]);
  end

endmodule

// File: rtl/afs_pulse_gen.sv
module afs_pulse_gen #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [N-1:0] bits,
  output logic [N-1:0] pulse
);

  logic [N-1:0] req;
  assign req = bits & {N{wr}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= '0;
    else        pulse <= req;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R11
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[i] |-> $past(wr && bits[i]));
    // R11
    pulse_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse[i] && !req[i]) |=> !pulse[i]);
  end

endmodule

// File: rtl/afs_req_combine.sv
module afs_req_combine
  import afs_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] need,
  input  logic [LANES-1:0] avail,
  input  logic [LANES-1:0] uf_vis,
  input  logic [LANES-1:0] of_q,
  input  logic [LANES-1:0] tx_en,
  input  logic [LANES-1:0] rx_en,
  input  logic             ien_tx,
  input  logic             ien_rx,
  input  logic             ien_err,
  input  logic             tx_dma_mode,
  input  logic             rx_dma_mode,
  output afs_req_t         req
);

  logic any_need, any_avail, any_err;
  logic tx_term, rx_term, err_term;

  assign any_need  = |(need & tx_en);
  assign any_avail = |(avail & rx_en);
  assign any_err   = |uf_vis | |of_q;

  assign tx_term  = ien_tx & ~tx_dma_mode & any_need;
  assign rx_term  = ien_rx & ~rx_dma_mode & any_avail;
  assign err_term = ien_err & any_err;

  assign req.irq    = tx_term | rx_term | err_term;
  assign req.tx_dma = tx_dma_mode & any_need;
  assign req.rx_dma = rx_dma_mode & any_avail;

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_tx && !ien_rx && !ien_err) |-> !req.irq);
  // R10
  txdma_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_dma_mode |-> !req.tx_dma);
  // R10
  rxdma_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dma_mode |-> !req.rx_dma);
  // R9 R10
  dma_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dma_mode && rx_dma_mode && !ien_err) |-> !req.irq);

endmodule

// File: rtl/audio_fifo_flags.sv
module audio_fifo_flags
  import afs_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int LVL_W       = 8,
  parameter int RX_FULL_LVL = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES*LVL_W-1:0] tx_level,
  input  logic [LANES*LVL_W-1:0] rx_level,
  input  logic [LANES-1:0]       tx_pop,
  input  logic [LANES-1:0]       rx_push,
  input  logic [LANES-1:0]       tx_lane_en,
  input  logic [LANES-1:0]       rx_lane_en,
  input  logic [LVL_W-1:0]       tx_thresh,
  input  logic [LVL_W-1:0]       rx_thresh,
  input  logic                   ien_tx_need,
  input  logic                   ien_rx_avail,
  input  logic                   ien_err,
  input  logic                   tx_dma_mode,
  input  logic                   rx_dma_mode,
  input  logic                   sta_wr,
  input  logic [LANES-1:0]       sta_uf_clr,
  input  logic [LANES-1:0]       sta_of_clr,
  input  logic                   ctl_wr,
  input  logic [CTL_NUM-1:0]     ctl_bits,
  output logic [LANES-1:0]       tx_need,
  output logic [LANES-1:0]       rx_avail,
  output logic [LANES-1:0]       tx_uflow,
  output logic [LANES-1:0]       rx_oflow,
  output logic                   irq,
  output logic                   tx_dma_req,
  output logic                   rx_dma_req,
  output logic [CTL_NUM-1:0]     ctl_pulse
);

  logic [LANES-1:0] uf_raw, uf_event, of_event;
  logic             uf_clr, of_clr;
  afs_req_t         req;

  assign uf_clr = sta_wr & (|sta_uf_clr);
  assign of_clr = sta_wr & (|sta_of_clr);

  afs_thresh_cmp #(.LANES(LANES), .LVL_W(LVL_W), .AT_LOW(1'b1)) u_tx_cmp (
    .level (tx_level),
    .thresh(tx_thresh),
    .flag  (tx_need)
  );

  afs_thresh_cmp #(.LANES(LANES), .LVL_W(LVL_W), .AT_LOW(1'b0)) u_rx_cmp (
    .level (rx_level),
    .thresh(rx_thresh),
    .flag  (rx_avail)
  );

  afs_err_latch #(.LANES(LANES), .LVL_W(LVL_W), .FULL_LVL(RX_FULL_LVL),
                  .UNDERFLOW(1'b1)) u_uf (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (tx_level),
    .strobe   (tx_pop),
    .lane_en  (tx_lane_en),
    .clr      (uf_clr),
    .err_q    (uf_raw),
    .err_event(uf_event)
  );

  afs_err_latch #(.LANES(LANES), .LVL_W(LVL_W), .FULL_LVL(RX_FULL_LVL),
                  .UNDERFLOW(1'b0)) u_of (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (rx_level),
    .strobe   (rx_push),
    .lane_en  (rx_lane_en),
    .clr      (of_clr),
    .err_q    (rx_oflow),
    .err_event(of_event)
  );

  assign tx_uflow = uf_raw & tx_lane_en;

  afs_req_combine #(.LANES(LANES)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .need       (tx_need),
    .avail      (rx_avail),
    .uf_vis     (tx_uflow),
    .of_q       (rx_oflow),
    .tx_en      (tx_lane_en),
    .rx_en      (rx_lane_en),
    .ien_tx     (ien_tx_need),
    .ien_rx     (ien_rx_avail),
    .ien_err    (ien_err),
    .tx_dma_mode(tx_dma_mode),
    .rx_dma_mode(rx_dma_mode),
    .req        (req)
  );

  assign irq        = req.irq;
  assign tx_dma_req = req.tx_dma;
  assign rx_dma_req = req.rx_dma;

  afs_pulse_gen #(.N(CTL_NUM)) u_pulse (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (ctl_wr),
    .bits (ctl_bits),
    .pulse(ctl_pulse)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    // R1 R2
    empty_needs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level[i*LVL_W +: LVL_W] == '0) |-> tx_need[i]);
    // R1 R3
    full_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level[i*LVL_W +: LVL_W] == '1) |-> rx_avail[i]);
    // R8
    uf_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_lane_en[i] && uf_event[i]) |=> (tx_uflow[i] || !tx_lane_en[i]));
    // R5
    of_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      of_event[i] |=> rx_oflow[i]);
  end

endmodule

// File: tb/tb_audio_fifo_flags.sv
module tb_audio_fifo_flags;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tx_level = '0, rx_level = '0;
  logic [3:0]  tx_pop = '0, rx_push = '0, tx_lane_en = '0, rx_lane_en = '0;
  logic [7:0]  tx_thresh = '0, rx_thresh = '0;
  logic        ien_tx_need = 0, ien_rx_avail = 0, ien_err = 0;
  logic        tx_dma_mode = 0, rx_dma_mode = 0;
  logic        sta_wr = 0;
  logic [3:0]  sta_uf_clr = '0, sta_of_clr = '0;
  logic        ctl_wr = 0;
  logic [4:0]  ctl_bits = '0;
  logic [3:0]  tx_need, rx_avail, tx_uflow, rx_oflow;
  logic        irq, tx_dma_req, rx_dma_req;
  logic [4:0]  ctl_pulse;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  audio_fifo_flags dut (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .tx_pop(tx_pop), .rx_push(rx_push), .tx_lane_en(tx_lane_en),
    .rx_lane_en(rx_lane_en), .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .ien_tx_need(ien_tx_need), .ien_rx_avail(ien_rx_avail), .ien_err(ien_err),
    .tx_dma_mode(tx_dma_mode), .rx_dma_mode(rx_dma_mode), .sta_wr(sta_wr),
    .sta_uf_clr(sta_uf_clr), .sta_of_clr(sta_of_clr), .ctl_wr(ctl_wr),
    .ctl_bits(ctl_bits), .tx_need(tx_need), .rx_avail(rx_avail),
    .tx_uflow(tx_uflow), .rx_oflow(rx_oflow), .irq(irq),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .ctl_pulse(ctl_pulse)
  );

  // lane 0 in the low byte
  function automatic logic [31:0] pk(input logic [7:0] l0, l1, l2, l3);
    return {l3, l2, l1, l0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, combinational outputs settle before #1
  task automatic edge_n();
    @(negedge clk);
  endtask

  task automatic t_reset();
    edge_n(); #1;
    chk("R12 uflow", 32'(tx_uflow), 0);
    chk("R12 oflow", 32'(rx_oflow), 0);
    chk("R12 pulse", 32'(ctl_pulse), 0);
    chk("R12 irq", 32'(irq), 0);
  endtask

  task automatic t_thresh();
    edge_n();
    tx_thresh = 8'd4; rx_thresh = 8'd10;
    tx_level = pk(3, 4, 5, 0); rx_level = pk(9, 10, 11, 255);
    #1;
    chk("R1 R2 need le", 32'(tx_need), 32'b1011);
    chk("R1 R3 avail ge", 32'(rx_avail), 32'b1110);
    tx_thresh = 8'd0; rx_thresh = 8'd0;
    tx_level = pk(0, 1, 0, 2); rx_level = pk(0, 7, 0, 3);
    #1;
    chk("R2 need zero thresh", 32'(tx_need), 32'b0101);
    chk("R3 avail zero thresh", 32'(rx_avail), 32'b1111);
  endtask

  task automatic t_underflow();
    edge_n();
    tx_thresh = 8'd4;
    tx_level = pk(0, 5, 0, 5); tx_lane_en = 4'b1110; tx_pop = 4'b0111;
    edge_n(); tx_pop = '0; #1;
    chk("R4 uflow set", 32'(tx_uflow), 32'b0100);
    edge_n(); #1;
    chk("R4 uflow held", 32'(tx_uflow), 32'b0100);
  endtask

  task automatic t_mask();
    edge_n(); tx_lane_en = 4'b1011; #1;
    chk("R8 uflow hidden", 32'(tx_uflow), 32'b0000);
    edge_n(); tx_lane_en = 4'b1111; #1;
    chk("R8 uflow shown again", 32'(tx_uflow), 32'b0100);
  endtask

  task automatic t_uf_clear();
    edge_n(); sta_wr = 1; sta_uf_clr = 4'b0000; sta_of_clr = 4'b1000;
    edge_n(); sta_wr = 0; sta_of_clr = '0; #1;
    chk("R6 zero field keeps uflow", 32'(tx_uflow), 32'b0100);
    edge_n(); sta_wr = 1; sta_uf_clr = 4'b0001;
    edge_n(); sta_wr = 0; sta_uf_clr = '0; #1;
    chk("R6 group clear uflow", 32'(tx_uflow), 32'b0000);
  endtask

  task automatic t_overflow();
    edge_n();
    rx_lane_en = 4'b1111; rx_thresh = 8'd10;
    rx_level = pk(16, 15, 16, 20); rx_push = 4'b1110;
    edge_n(); rx_push = '0; #1;
    chk("R5 oflow set", 32'(rx_oflow), 32'b1100);
    sta_wr = 1; sta_uf_clr = 4'b1111;
    edge_n(); sta_wr = 0; sta_uf_clr = '0; #1;
    chk("R6 uf clear spares oflow", 32'(rx_oflow), 32'b1100);
  endtask

  task automatic t_priority();
    edge_n(); sta_wr = 1; sta_of_clr = 4'b0001; rx_push = 4'b0001;
    edge_n(); sta_wr = 0; sta_of_clr = '0; rx_push = '0; #1;
    chk("R7 event beats clear", 32'(rx_oflow), 32'b0001);
    sta_wr = 1; sta_of_clr = 4'b0100;
    edge_n(); sta_wr = 0; sta_of_clr = '0; #1;
    chk("R6 oflow cleared", 32'(rx_oflow), 32'b0000);
  endtask

  task automatic t_irq_dma();
    edge_n();
    tx_thresh = 8'd4; rx_thresh = 8'd10;
    tx_level = pk(5, 5, 5, 5); rx_level = pk(0, 0, 0, 0);
    tx_lane_en = 4'b1111; rx_lane_en = 4'b1111;
    ien_tx_need = 1; ien_rx_avail = 1; ien_err = 1; #1;
    chk("R9 no source", 32'(irq), 0);
    tx_level = pk(5, 5, 2, 5); #1;
    chk("R9 tx need irq", 32'(irq), 1);
    tx_dma_mode = 1; #1;
    chk("R9 dma removes tx term", 32'(irq), 0);
    chk("R10 tx dma req", 32'(tx_dma_req), 1);
    tx_lane_en = 4'b1011; #1;
    chk("R10 tx dma only enabled lanes", 32'(tx_dma_req), 0);
    tx_lane_en = 4'b1111; tx_level = pk(0, 5, 5, 5); tx_pop = 4'b0001;
    edge_n(); tx_pop = '0; #1;
    chk("R9 err irq", 32'(irq), 1);
    ien_err = 0; #1;
    chk("R9 err masked", 32'(irq), 0);
    ien_rx_avail = 0; rx_dma_mode = 1; rx_level = pk(0, 0, 0, 12); #1;
    chk("R10 rx dma without enable", 32'(rx_dma_req), 1);
    chk("R9 rx not irq in dma", 32'(irq), 0);
    rx_dma_mode = 0; ien_rx_avail = 1; #1;
    chk("R9 rx avail irq", 32'(irq), 1);
    chk("R10 rx dma off", 32'(rx_dma_req), 0);
  endtask

  task automatic t_pulses();
    edge_n(); ctl_wr = 1; ctl_bits = 5'b10101;
    edge_n(); ctl_wr = 0; ctl_bits = '0; #1;
    chk("R11 pulse high", 32'(ctl_pulse), 32'b10101);
    edge_n(); #1;
    chk("R11 pulse self clear", 32'(ctl_pulse), 0);
    ctl_bits = 5'b01010;
    edge_n(); #1;
    chk("R11 no strobe no pulse", 32'(ctl_pulse), 0);
    ctl_wr = 1;
    edge_n(); ctl_wr = 0; ctl_bits = '0; #1;
    chk("R11 pulse other bits", 32'(ctl_pulse), 32'b01010);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_thresh();
    t_underflow();
    t_mask();
    t_uf_clear();
    t_overflow();
    t_priority();
    t_irq_dma();
    t_pulses();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule